// File: doc/BRIEF.md
# Dual-Chain Add-With-Flag Unit

This unit adds two 64-bit operands with a one-bit incoming term taken from one of two status flags. It is meant for multi-precision arithmetic, where long integers are summed limb by limb. A mode input chooses which flag acts as the chain.

In carry-chain mode, the incoming carry flag is the carry-in, and the unsigned carry out of the top bit becomes the new carry flag. In overflow-chain mode, the incoming overflow flag is the carry-in, and the signed-overflow condition of the addition becomes the new overflow flag.

Each operation updates exactly one flag. A one-hot write-enable tells downstream flag storage which flag to take, so all other flags stay as they were. Two independent carry chains can therefore be interleaved in one instruction stream. Results are registered and appear one clock after an operation is issued with `op_valid`.

Top module: `dcadd_top`

## Requirements
- R1: With `mode_ovf` = 0, `sum_q` equals (`opa` + `opb` + `cf_in`) modulo 2^64.
- R2: With `mode_ovf` = 0, `flag_val` is the unsigned carry out of bit 63 of that addition.
- R3: With `mode_ovf` = 1, `sum_q` equals (`opa` + `opb` + `of_in`) modulo 2^64.
- R4: With `mode_ovf` = 1, `flag_val` is 1 exactly when `opa[63]` equals `opb[63]` and the sum's bit 63 differs from them.
- R5: `flag_we` is 2'b01 (bit 0 = carry flag) after a carry-chain operation and 2'b10 (bit 1 = overflow flag) after an overflow-chain operation. The flag not selected by the mode has no effect on `sum_q` or `flag_val`.
- R6: Results of an operation issued with `op_valid` = 1 appear on the outputs after the next rising clock edge and not before it.
- R7: In a cycle with `op_valid` = 0, `flag_we` becomes 2'b00 and `sum_q` and `flag_val` keep their values.
- R8: While `rst_n` is low, `sum_q` = 0, `flag_val` = 0 and `flag_we` = 2'b00.
- R9: `flag_we` never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Issue an operation this cycle |
| mode_ovf | input | 1 | 0 = carry-flag chain, 1 = overflow-flag chain |
| opa | input | 64 | First operand |
| opb | input | 64 | Second operand |
| cf_in | input | 1 | Incoming carry flag |
| of_in | input | 1 | Incoming overflow flag |
| sum_q | output | 64 | Registered sum |
| flag_val | output | 1 | New value for the selected flag |
| flag_we | output | 2 | One-hot flag write-enable: bit 0 carry, bit 1 overflow |

## Verification
An unsigned carry out of bit 63 and a signed overflow can arise from the same addition. The point to judge is that overflow-chain mode reports only the signed condition, and carry-chain mode only the unsigned one.

The vector table provokes this case in several ways:
- all-ones plus one plus a carry-in, which carries out but does not overflow;
- the most negative value added to itself, which does both;
- the largest positive value plus a carry-in, which overflows without a carry out.

In each case the bench checks the flag value against its own 65-bit model of the sum and signs, and checks that the one-hot enable names the flag of the requested chain only.

// File: rtl/dcadd_pkg.sv
package dcadd_pkg;
  typedef enum logic {
    MODE_CARRY = 1'b0,
    MODE_OVF   = 1'b1
  } chain_mode_e;

  localparam int FLAG_CF   = 0;
  localparam int FLAG_OV   = 1;
  localparam int NUM_FLAGS = 2;
endpackage

// File: rtl/dcadd_cin_sel.sv
module dcadd_cin_sel
  import dcadd_pkg::*;
(
  input  chain_mode_e mode,
  input  logic        cf_in,
  input  logic        of_in,
  output logic        cin
);
  always_comb begin
    cin = (mode == MODE_OVF) ? of_in : cf_in;
  end
endmodule

// File: rtl/dcadd_core.sv
module dcadd_core #(
  parameter int W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  localparam int MSB = W - 1;

  function automatic logic [W-1:0] add3(input logic [W-1:0] x, input logic [W-1:0] y,
                                        input logic c);
    return x + y + {{(W-1){1'b0}}, c};
  endfunction

  // Carry out of every bit position, recovered from operands and sum
  function automatic logic [W-1:0] carry_vec(input logic [W-1:0] x, input logic [W-1:0] y,
                                             input logic [W-1:0] s);
    return (x & y) | ((x | y) & ~s);
  endfunction

  // Signed overflow: like-signed operands giving a result of the other sign
  function automatic logic signed_ovf(input logic xs, input logic ys, input logic ss);
    return (xs == ys) && (ss != xs);
  endfunction

  logic [W-1:0] cvec;      // carry out of each bit
  logic [W-1:0] cin_vec;   // carry into each bit

  always_comb begin
    sum     = add3(a, b, cin);
    cvec    = carry_vec(a, b, sum);
    cin_vec = a ^ b ^ sum;
    cout    = cvec[MSB];
    ovf     = signed_ovf(a[MSB], b[MSB], sum[MSB]);
  end

  always_comb begin
    AST_CARRY_RIPPLE: assert (cvec[W-2:0] == cin_vec[W-1:1]) else $error("carry ripple mismatch"); // R1
    AST_CARRY_ENTRY: assert (cin_vec[0] == cin) else $error("carry entry mismatch"); // R3
    AST_OVF_XOR: assert (ovf == (cvec[MSB] ^ cin_vec[MSB])) else $error("overflow rule mismatch"); // R4
  end
endmodule

// File: rtl/dcadd_flag_sel.sv
module dcadd_flag_sel
  import dcadd_pkg::*;
(
  input  chain_mode_e          mode,
  input  logic                 valid,
  input  logic                 cout,
  input  logic                 ovf,
  output logic                 flag_next,
  output logic [NUM_FLAGS-1:0] we_next
);
  always_comb begin
    flag_next = (mode == MODE_OVF) ? ovf : cout;
  end

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_we
    localparam chain_mode_e OWNER = (f == FLAG_OV) ? MODE_OVF : MODE_CARRY;
    assign we_next[f] = valid && (mode == OWNER);
  end

  always_comb begin
    AST_WE_NEXT_ONEHOT: assert ($onehot0(we_next)) else $error("next enable not one-hot"); // R9
  end
endmodule

// File: rtl/dcadd_top.sv
module dcadd_top
  import dcadd_pkg::*;
#(
  parameter int W = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 op_valid,
  input  logic                 mode_ovf,
  input  logic [W-1:0]         opa,
  input  logic [W-1:0]         opb,
  input  logic                 cf_in,
  input  logic                 of_in,
  output logic [W-1:0]         sum_q,
  output logic                 flag_val,
  output logic [NUM_FLAGS-1:0] flag_we
);
  chain_mode_e          mode;
  logic                 cin;
  logic [W-1:0]         sum_c;
  logic                 cout_c;
  logic                 ovf_c;
  logic                 flag_c;
  logic [NUM_FLAGS-1:0] we_c;

  assign mode = chain_mode_e'(mode_ovf);

  dcadd_cin_sel u_cin (
    .mode  (mode),
    .cf_in (cf_in),
    .of_in (of_in),
    .cin   (cin)
  );

  dcadd_core #(.W(W)) u_core (
    .a    (opa),
    .b    (opb),
    .cin  (cin),
    .sum  (sum_c),
    .cout (cout_c),
    .ovf  (ovf_c)
  );

  dcadd_flag_sel u_flag (
    .mode      (mode),
    .valid     (op_valid),
    .cout      (cout_c),
    .ovf       (ovf_c),
    .flag_next (flag_c),
    .we_next   (we_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum_q    <= '0;
      flag_val <= 1'b0;
      flag_we  <= '0;
    end else begin
      flag_we <= we_c;
      if (op_valid) begin
        sum_q    <= sum_c;
        flag_val <= flag_c;
      end
    end
  end

  AST_WE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flag_we)) else $error("flag_we not one-hot"); // R9
  AST_WE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> (flag_we == (($past(mode_ovf)) ? 2'b10 : 2'b01))) else $error("wrong flag enabled"); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(sum_q) && $stable(flag_val) && flag_we == '0)) else $error("idle changed state"); // R7
endmodule

// File: tb/dcadd_top_tb.sv
module dcadd_top_tb;
  localparam int W = 64;
  localparam int NV = 9;
  localparam logic [W-1:0] ONES = {W{1'b1}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};

  // stimulus: mode, a, b, cf, of ; expected: sum, flag
  localparam logic         T_MODE [NV] = '{0, 0, 0, 0, 1, 1, 1, 1, 1};
  localparam logic [W-1:0] T_A    [NV] = '{64'd1, ONES, MINV, MAXV, MAXV, ONES, MINV, MINV, 64'd5};
  localparam logic [W-1:0] T_B    [NV] = '{64'd2, 64'd0, MINV, 64'd1, 64'd0, 64'd1, MINV, ONES, 64'd7};
  localparam logic         T_CF   [NV] = '{0, 1, 0, 0, 0, 1, 1, 0, 0};
  localparam logic         T_OF   [NV] = '{1, 0, 1, 1, 1, 0, 0, 1, 1};
  localparam logic [W-1:0] T_SUM  [NV] = '{64'd3, 64'd0, 64'd0, MINV, MINV, 64'd0, 64'd0, MINV, 64'd13};
  localparam logic         T_FLG  [NV] = '{0, 1, 1, 0, 1, 0, 1, 0, 0};

  logic clk = 0;
  logic rst_n = 0;
  logic op_valid = 0;
  logic mode_ovf = 0;
  logic [W-1:0] opa = '0;
  logic [W-1:0] opb = '0;
  logic cf_in = 0;
  logic of_in = 0;
  logic [W-1:0] sum_q;
  logic flag_val;
  logic [1:0] flag_we;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  dcadd_top #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .mode_ovf(mode_ovf),
    .opa(opa), .opb(opb), .cf_in(cf_in), .of_in(of_in),
    .sum_q(sum_q), .flag_val(flag_val), .flag_we(flag_we)
  );

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // independent model: 65-bit add and sign comparison
  function automatic logic [W:0] model_add(input logic [W-1:0] a, input logic [W-1:0] b,
                                           input logic c);
    return {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
  endfunction

  task automatic issue(input logic m, input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic cf, input logic of);
    op_valid = 1; mode_ovf = m; opa = a; opb = b; cf_in = cf; of_in = of;
  endtask

  initial begin
    #4000000;
    n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [W:0] mdl;
    logic [W-1:0] held;
    logic m_flag;
    // R8: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(sum_q == '0, "R8 sum", sum_q, '0);
    chk(flag_val == 1'b0, "R8 flag", {63'd0, flag_val}, '0);
    chk(flag_we == 2'b00, "R8 we", {62'd0, flag_we}, '0);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      issue(T_MODE[i], T_A[i], T_B[i], T_CF[i], T_OF[i]);
      @(posedge clk);
      @(negedge clk);
      mdl = model_add(T_A[i], T_B[i], T_MODE[i] ? T_OF[i] : T_CF[i]);
      m_flag = T_MODE[i] ? ((T_A[i][W-1] == T_B[i][W-1]) && (mdl[W-1] != T_A[i][W-1])) : mdl[W];
      chk(mdl[W-1:0] == T_SUM[i] && m_flag == T_FLG[i], "table self-consistency", {63'd0, m_flag}, {63'd0, T_FLG[i]});
      if (T_MODE[i]) begin
        chk(sum_q == T_SUM[i], "R3 sum", sum_q, T_SUM[i]);
        chk(flag_val == T_FLG[i], "R4 overflow flag", {63'd0, flag_val}, {63'd0, T_FLG[i]});
        chk(flag_we == 2'b10, "R5 we overflow", {62'd0, flag_we}, 64'd2);
      end else begin
        chk(sum_q == T_SUM[i], "R1 sum", sum_q, T_SUM[i]);
        chk(flag_val == T_FLG[i], "R2 carry flag", {63'd0, flag_val}, {63'd0, T_FLG[i]});
        chk(flag_we == 2'b01, "R5 we carry", {62'd0, flag_we}, 64'd1);
      end
      chk($countones(flag_we) <= 1, "R9 onehot", {62'd0, flag_we}, 64'd1);
    end

    // R5: the unselected flag has no effect
    issue(1'b0, 64'd10, 64'd20, 1'b1, 1'b0);
    @(posedge clk); @(negedge clk);
    held = sum_q;
    issue(1'b0, 64'd10, 64'd20, 1'b1, 1'b1);
    @(posedge clk); @(negedge clk);
    chk(sum_q == held && sum_q == 64'd31, "R5 of ignored in carry mode", sum_q, 64'd31);
    issue(1'b1, MAXV, 64'd0, 1'b1, 1'b0);
    @(posedge clk); @(negedge clk);
    chk(sum_q == MAXV && flag_val == 1'b0, "R5 cf ignored in overflow mode", sum_q, MAXV);

    // R7: idle cycle holds state and clears enable
    issue(1'b0, ONES, ONES, 1'b1, 1'b1);
    op_valid = 0;
    @(posedge clk); @(negedge clk);
    chk(sum_q == MAXV, "R7 sum held", sum_q, MAXV);
    chk(flag_val == 1'b0, "R7 flag held", {63'd0, flag_val}, 64'd0);
    chk(flag_we == 2'b00, "R7 we cleared", {62'd0, flag_we}, 64'd0);

    // R6: no output change before the edge
    issue(1'b0, 64'd100, 64'd23, 1'b0, 1'b0);
    #5;
    chk(sum_q == MAXV, "R6 before edge", sum_q, MAXV);
    @(posedge clk); @(negedge clk);
    chk(sum_q == 64'd123, "R6 after edge", sum_q, 64'd123);
    op_valid = 0;

    // R8: synchronous reset clears after activity
    rst_n = 0;
    @(posedge clk); @(negedge clk);
    chk(sum_q == '0 && flag_we == 2'b00, "R8 re-reset", sum_q, '0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule